// File: doc/BRIEF.md
# Echoing Response Frame Transmitter

This block produces the byte stream that a two-wire bus slave returns during a read transaction that follows a request packet. A command handler first loads three things: the feature and command codes of the request, the response payload length, and the payload bytes in a small buffer. The bus engine then signals the start of the read and asks for bytes one at a time. Each request is answered one cycle later with the next byte of the frame.

The frame has a fixed order. The feature code comes first, then the command code. Next comes the payload length as two bytes, most significant first. The payload bytes follow. The frame ends with a two-byte checksum, low byte first. The checksum is a bit-reflected CRC-16 built on the generator 0x1021. It starts from 0xFFFF, applies no final inversion, and covers every byte from the feature code through the last payload byte. It is accumulated as the bytes go out, so no second pass over the buffer is needed.

A status reply is just a frame with a one-byte payload. A memory read reply carries only the data words, because the handler loads only those. A master that keeps reading past the checksum receives 0xFF filler. Any new read start rewinds the frame to its first byte.

Top module: `respPacketTx`

## Requirements
- R1: `txValid` is high for exactly one cycle, the cycle after a clock edge where `byteReq` was high and `rdStart` was low. It is low at all other times, and `txData` holds the served byte while `txValid` is high.
- R2: Byte 0 of a frame is the feature code and byte 1 is the command code. Both are the values captured at the most recent `reqWrEn`.
- R3: Bytes 2 and 3 are the stored payload length as a 16-bit value, with bits 15:8 first and bits 7:0 second.
- R4: With a stored length N, bytes 4 to 3+N are buffer entries 0 to N-1, in that order. When N is 0, the checksum follows byte 3 directly.
- R5: The two bytes after the payload are a CRC-16 over frame bytes 0 to 3+N. Its parameters are: reflected input and output, generator 0x1021 (0x8408 in shift-right form), start value 0xFFFF, and no final XOR. Bits 7:0 are sent first, then bits 15:8.
- R6: Every byte requested after the second checksum byte is 0xFF, however many are requested. The frame is unaffected: a later restart serves the same frame.
- R7: A cycle with `rdStart` high rewinds to frame byte 0 and restarts the checksum, so a reread yields an identical frame. A `byteReq` in that same cycle is dropped and produces no `txValid`.
- R8: A length written above MAX_PAYLOAD (default 256) is stored as MAX_PAYLOAD.
- R9: After reset, `txValid` and `txData` are 0, and the stored feature, command and length are 0. The first frame read is therefore four zero bytes followed by the checksum of those four bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqWrEn | input | 1 | Captures the feature and command codes |
| reqFeature | input | 8 | Feature code to echo |
| reqCommand | input | 8 | Command code to echo |
| lenWrEn | input | 1 | Captures the payload length |
| lenWrData | input | 16 | Payload length, clamped to MAX_PAYLOAD |
| bufWrEn | input | 1 | Writes one payload buffer entry |
| bufWrAddr | input | BUF_AW | Buffer entry index |
| bufWrData | input | 8 | Buffer entry value |
| rdStart | input | 1 | START or repeated START with the read bit: rewinds the frame |
| byteReq | input | 1 | Request for the next response byte |
| txData | output | 8 | Served response byte |
| txValid | output | 1 | One-cycle strobe marking `txData` as new |

## Verification
A wrong byte pointer shows up at the very next served byte. The byte lands in the wrong field: for example, an echoed code appears where a length byte should be, or filler appears too early. A corrupted checksum register stays hidden until the two trailer bytes, which can be a full payload later. For that reason every frame is compared in full against a checksum that the bench computes itself, with long frames included. A restart that fails to clear state shows only on the reread, so frames are read again after partial reads and after filler reads.

// File: rtl/respTxPkg.sv
package respTxPkg;

  // Source of the byte served for the current frame position
  typedef enum logic [2:0] {
    SRC_FEAT,
    SRC_CMD,
    SRC_LENH,
    SRC_LENL,
    SRC_DATA,
    SRC_CRCL,
    SRC_CRCH,
    SRC_FILL
  } srcSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    restart;
    logic    emit;
    logic    crcUpd;
    srcSel_e src;
  } txStrobe_t;

  // One byte through the bit-reflected CRC-16 (0x1021 reversed = 0x8408)
  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] dIn);
    logic [15:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ dIn[i]) c = (c >> 1) ^ 16'h8408;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/txCtrl.sv
module txCtrl
  import respTxPkg::*;
#(
  parameter int MAX_PAYLOAD = 256,
  localparam int LEN_W  = $clog2(MAX_PAYLOAD + 1),
  localparam int PTR_W  = $clog2(MAX_PAYLOAD + 7),
  localparam int BUF_AW = $clog2(MAX_PAYLOAD)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStart,
  input  logic              byteReq,
  input  logic [LEN_W-1:0]  payLen,
  output txStrobe_t         strb,
  output logic [BUF_AW-1:0] dataIdx
);

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] dataEnd;
  logic [PTR_W-1:0] frameEnd;
  srcSel_e          srcNow;

  assign dataEnd  = PTR_W'(payLen) + PTR_W'(4);
  assign frameEnd = dataEnd + PTR_W'(2);
  assign dataIdx  = BUF_AW'(ptr - PTR_W'(4));

  // Frame position decode
  always_comb begin
    if (ptr == PTR_W'(0))               srcNow = SRC_FEAT;
    else if (ptr == PTR_W'(1))          srcNow = SRC_CMD;
    else if (ptr == PTR_W'(2))          srcNow = SRC_LENH;
    else if (ptr == PTR_W'(3))          srcNow = SRC_LENL;
    else if (ptr < dataEnd)             srcNow = SRC_DATA;
    else if (ptr == dataEnd)            srcNow = SRC_CRCL;
    else if (ptr == dataEnd + PTR_W'(1)) srcNow = SRC_CRCH;
    else                                srcNow = SRC_FILL;
  end

  always_comb begin
    strb.restart = rdStart;
    strb.emit    = byteReq & ~rdStart;
    strb.crcUpd  = strb.emit & (ptr < dataEnd);
    strb.src     = srcNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                ptr <= '0;
    else if (strb.restart)                    ptr <= '0;
    else if (strb.emit && (ptr < frameEnd))   ptr <= ptr + PTR_W'(1);
  end

  // R6
  fill_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && srcNow == SRC_FILL) |=> $stable(ptr));

  // R7
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStart && !byteReq) |=> $stable(ptr));

endmodule

// File: rtl/txDatapath.sv
module txDatapath
  import respTxPkg::*;
#(
  parameter int MAX_PAYLOAD = 256,
  localparam int LEN_W  = $clog2(MAX_PAYLOAD + 1),
  localparam int BUF_AW = $clog2(MAX_PAYLOAD)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrEn,
  input  logic [7:0]        reqFeature,
  input  logic [7:0]        reqCommand,
  input  logic              lenWrEn,
  input  logic [15:0]       lenWrData,
  input  logic              bufWrEn,
  input  logic [BUF_AW-1:0] bufWrAddr,
  input  logic [7:0]        bufWrData,
  input  txStrobe_t         strb,
  input  logic [BUF_AW-1:0] dataIdx,
  output logic [LEN_W-1:0]  payLen,
  output logic [7:0]        txData,
  output logic              txValid
);

  logic [7:0]  featReg;
  logic [7:0]  cmdReg;
  logic [15:0] crcReg;
  logic [15:0] len16;
  logic [7:0]  curByte;
  logic [7:0]  payBuf [MAX_PAYLOAD];

  assign len16 = 16'(payLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      featReg <= '0;
      cmdReg  <= '0;
    end else if (reqWrEn) begin
      featReg <= reqFeature;
      cmdReg  <= reqCommand;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) payLen <= '0;
    else if (lenWrEn) begin
      if (lenWrData > 16'(MAX_PAYLOAD)) payLen <= LEN_W'(MAX_PAYLOAD);
      else                              payLen <= LEN_W'(lenWrData);
    end
  end

  always_ff @(posedge clk) begin
    if (bufWrEn) payBuf[bufWrAddr] <= bufWrData;
  end

  always_comb begin
    case (strb.src)
      SRC_FEAT: curByte = featReg;
      SRC_CMD:  curByte = cmdReg;
      SRC_LENH: curByte = len16[15:8];
      SRC_LENL: curByte = len16[7:0];
      SRC_DATA: curByte = payBuf[dataIdx];
      SRC_CRCL: curByte = crcReg[7:0];
      SRC_CRCH: curByte = crcReg[15:8];
      default:  curByte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              crcReg <= 16'hFFFF;
    else if (strb.restart)  crcReg <= 16'hFFFF;
    else if (strb.crcUpd)   crcReg <= crcStep(crcReg, curByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= strb.emit;
      if (strb.emit) txData <= curByte;
    end
  end

  // R5
  crc_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (crcReg == 16'hFFFF));

  // R5
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.restart && !strb.crcUpd) |=> $stable(crcReg));

  // R6
  fill_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && strb.src == SRC_FILL) |=> (txData == 8'hFF));

  // R8
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    payLen <= LEN_W'(MAX_PAYLOAD));

endmodule

// File: rtl/respPacketTx.sv
module respPacketTx
  import respTxPkg::*;
#(
  parameter int MAX_PAYLOAD = 256,
  localparam int LEN_W  = $clog2(MAX_PAYLOAD + 1),
  localparam int BUF_AW = $clog2(MAX_PAYLOAD)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrEn,
  input  logic [7:0]        reqFeature,
  input  logic [7:0]        reqCommand,
  input  logic              lenWrEn,
  input  logic [15:0]       lenWrData,
  input  logic              bufWrEn,
  input  logic [BUF_AW-1:0] bufWrAddr,
  input  logic [7:0]        bufWrData,
  input  logic              rdStart,
  input  logic              byteReq,
  output logic [7:0]        txData,
  output logic              txValid
);

  txStrobe_t         strb;
  logic [BUF_AW-1:0] dataIdx;
  logic [LEN_W-1:0]  payLen;

  txCtrl #(.MAX_PAYLOAD(MAX_PAYLOAD)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdStart (rdStart),
    .byteReq (byteReq),
    .payLen  (payLen),
    .strb    (strb),
    .dataIdx (dataIdx)
  );

  txDatapath #(.MAX_PAYLOAD(MAX_PAYLOAD)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqWrEn    (reqWrEn),
    .reqFeature (reqFeature),
    .reqCommand (reqCommand),
    .lenWrEn    (lenWrEn),
    .lenWrData  (lenWrData),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .strb       (strb),
    .dataIdx    (dataIdx),
    .payLen     (payLen),
    .txData     (txData),
    .txValid    (txValid)
  );

  // R1
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> ($past(byteReq) && !$past(rdStart)));

endmodule

// File: tb/respPacketTx_tb.sv
`timescale 1ns/1ps
module respPacketTx_tb_top;

  localparam int MAXP = 256;
  localparam int AW   = $clog2(MAXP);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqWrEn = 1'b0;
  logic [7:0]    reqFeature = '0;
  logic [7:0]    reqCommand = '0;
  logic          lenWrEn = 1'b0;
  logic [15:0]   lenWrData = '0;
  logic          bufWrEn = 1'b0;
  logic [AW-1:0] bufWrAddr = '0;
  logic [7:0]    bufWrData = '0;
  logic          rdStart = 1'b0;
  logic          byteReq = 1'b0;
  logic [7:0]    txData;
  logic          txValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] shadow [MAXP];
  logic [7:0] expF   [MAXP + 6];
  int         expN;
  logic [7:0] mFeat = 0, mCmd = 0;
  int         mLen = 0;

  always #2.5 clk = ~clk;

  respPacketTx #(.MAX_PAYLOAD(MAXP)) dut_i (
    .clk(clk), .rstN(rstN),
    .reqWrEn(reqWrEn), .reqFeature(reqFeature), .reqCommand(reqCommand),
    .lenWrEn(lenWrEn), .lenWrData(lenWrData),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .rdStart(rdStart), .byteReq(byteReq),
    .txData(txData), .txValid(txValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // Independent model: MSB-first CRC on bit-reversed input, result reversed
  function automatic logic [15:0] modelCrc(input int n);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] r;
    for (int k = 0; k < n; k++) begin
      c = c ^ {rev8(expF[k]), 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    for (int i = 0; i < 16; i++) r[i] = c[15-i];
    return r;
  endfunction

  task automatic buildExp();
    logic [15:0] crc;
    expF[0] = mFeat;
    expF[1] = mCmd;
    expF[2] = 8'(mLen >> 8);
    expF[3] = 8'(mLen);
    for (int i = 0; i < mLen; i++) expF[4+i] = shadow[i];
    crc = modelCrc(4 + mLen);
    expF[4+mLen] = crc[7:0];
    expF[5+mLen] = crc[15:8];
    expN = 6 + mLen;
  endtask

  task automatic loadReq(input logic [7:0] f, input logic [7:0] c);
    @(negedge clk); reqWrEn = 1; reqFeature = f; reqCommand = c;
    @(negedge clk); reqWrEn = 0;
    mFeat = f; mCmd = c;
  endtask

  task automatic loadLen(input int l);
    @(negedge clk); lenWrEn = 1; lenWrData = 16'(l);
    @(negedge clk); lenWrEn = 0;
    mLen = (l > MAXP) ? MAXP : l;
  endtask

  task automatic loadBuf(input int i, input logic [7:0] d);
    @(negedge clk); bufWrEn = 1; bufWrAddr = AW'(i); bufWrData = d;
    @(negedge clk); bufWrEn = 0;
    shadow[i] = d;
  endtask

  task automatic restart();
    @(negedge clk); rdStart = 1;
    @(negedge clk); rdStart = 0;
  endtask

  task automatic readByte(output logic [7:0] b, output logic v);
    @(negedge clk); byteReq = 1;
    @(negedge clk); byteReq = 0;
    b = txData; v = txValid;
  endtask

  task automatic expectFrame();
    logic [7:0] b;
    logic v;
    buildExp();
    for (int k = 0; k < expN; k++) begin
      readByte(b, v);
      check(v == 1'b1, "R1 valid", v, 1);
      if (k < 2)              check(b == expF[k], "R2 echo", b, expF[k]);
      else if (k < 4)         check(b == expF[k], "R3 length", b, expF[k]);
      else if (k < 4 + mLen)  check(b == expF[k], "R4 payload", b, expF[k]);
      else                    check(b == expF[k], "R5 crc", b, expF[k]);
    end
  endtask

  task automatic testReset();
    check(txValid == 1'b0, "R9 valid", txValid, 0);
    check(txData == 8'h00, "R9 data", txData, 0);
    restart();
    expectFrame();
  endtask

  task automatic testStatus();
    loadReq(8'h80, 8'h02);
    loadLen(1);
    loadBuf(0, 8'h5A);
    restart();
    expectFrame();
  endtask

  task automatic testMemRead();
    loadReq(8'h8A, 8'h01);
    loadLen(4);
    loadBuf(0, 8'hDE); loadBuf(1, 8'hAD); loadBuf(2, 8'hBE); loadBuf(3, 8'hEF);
    restart();
    expectFrame();
  endtask

  task automatic testEmpty();
    loadReq(8'h51, 8'h08);
    loadLen(0);
    restart();
    expectFrame();
  endtask

  task automatic testOverRead();
    logic [7:0] b;
    logic v;
    loadReq(8'h8A, 8'h01);
    loadLen(4);
    restart();
    expectFrame();
    for (int i = 0; i < 3; i++) begin
      readByte(b, v);
      check(v == 1'b1, "R6 valid", v, 1);
      check(b == 8'hFF, "R6 fill", b, 8'hFF);
    end
    restart();
    expectFrame();
  endtask

  task automatic testRestartMid();
    logic [7:0] b;
    logic v;
    loadReq(8'h80, 8'h02);
    loadLen(1);
    loadBuf(0, 8'h3C);
    restart();
    for (int i = 0; i < 3; i++) readByte(b, v);
    restart();
    expectFrame();
    // R7: request coinciding with restart is dropped
    @(negedge clk); rdStart = 1; byteReq = 1;
    @(negedge clk); rdStart = 0; byteReq = 0;
    check(txValid == 1'b0, "R7 dropped", txValid, 0);
    readByte(b, v);
    check(b == 8'h80, "R7 rewind", b, 8'h80);
  endtask

  task automatic testIdle();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(txValid == 1'b0, "R1 idle", txValid, 0);
    end
  endtask

  task automatic testMax();
    logic [7:0] b;
    logic v;
    loadReq(8'h8A, 8'h01);
    for (int i = 0; i < MAXP; i++) loadBuf(i, 8'(i * 7 + 3));
    loadLen(300);
    restart();
    readByte(b, v);
    readByte(b, v);
    readByte(b, v);
    check(b == 8'h01, "R8 clamp hi", b, 8'h01);
    readByte(b, v);
    check(b == 8'h00, "R8 clamp lo", b, 8'h00);
    restart();
    expectFrame();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testIdle();
    testStatus();
    testMemRead();
    testEmpty();
    testOverRead();
    testRestartMid();
    testMax();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule